// File: doc/BRIEF.md
# Tri-State PWM Gate Sequencer

This block turns a decoded three-level PWM command into the two gate commands of a synchronous buck power stage: one for the high-side switch and one for the low-side switch. Before either gate is raised, the opposite gate is dropped. The block then waits until sense flags report that the opposite device is really off and counts a programmable dead time. Only after that does it raise the gate. This gives a non-overlap interval that adapts to how slowly the power devices turn off.

A mid-level command starts diode emulation. Both gates go low, and after the dead time the low-side gate is raised. It is held high for a blanking window and then released when the zero-cross flag fires. A low command also starts a timeout. If the switch node never reports low, as happens when the high-side switch is shorted, the low-side gate is forced on when the timeout expires. An enable permission input forces both gates low whenever it is deasserted. All delays are parameters counted in clock cycles.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: While the active-low asynchronous reset is asserted, both gate outputs are low, and they stay low until a command is sequenced.
- R2: A high command drops the low-side gate at the next edge. The block then waits for the low-side off sense, spends DEAD_CYC cycles in dead time, and raises the high-side gate.
- R3: A low command drops the high-side gate at the next edge. Once the high-side off sense and the switch-node-low flag are both seen in the same cycle, the block spends DEAD_CYC cycles in dead time and raises the low-side gate.
- R4: When a low command is registered, a timeout of TOUT_CYC cycles starts. If the dead-time path has not begun when it expires, the low-side gate is raised at once. Expiry takes priority over a switch-node-low flag seen in the same cycle.
- R5: A mid command drives both gates low. After the high-side off sense and DEAD_CYC cycles of dead time, the low-side gate is raised.
- R6: In mid mode the low-side gate stays high for BLANK_CYC cycles, and the zero-cross flag is ignored during that window.
- R7: After blanking, a zero-cross flag drops the low-side gate at the next edge. Both gates then stay low until a new command arrives.
- R8: When enable is low, both gates are low from the next edge. When enable returns, the current command is sequenced from its turn-off step.
- R9: The two gate outputs are never high in the same cycle.
- R10: A command change during any step aborts the current sequence and starts the new one from its turn-off step. A command change takes priority over any timer expiry in the same cycle.
- R11: The command encoding is 2'b00 low, 2'b01 high and 2'b10 mid. The code 2'b11 is treated as mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_state | input | 2 | Decoded PWM level: 00 low, 01 high, 10/11 mid |
| en_ok | input | 1 | Gate drive permission; low forces both gates off |
| sw_low | input | 1 | Switch node sensed low |
| hs_off_sense | input | 1 | High-side gate sensed off |
| ls_off_sense | input | 1 | Low-side gate sensed off |
| zc_det | input | 1 | Inductor current zero-cross detected |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
Two functions can fall in the same cycle: the shorted-switch timeout expiring and the switch node reporting low. The bench holds the switch-node flag low through a whole timeout and raises it exactly in the expiry cycle. The low-side gate must then rise at that very edge, with no dead-time cycles inserted, so the forced path is seen to win. Separately, a low command is issued in the middle of a high-side dead time to confirm that the abort discards the running dead-time count.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    CMD_LO  = 2'd0,
    CMD_HI  = 2'd1,
    CMD_MID = 2'd2
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HS_WAIT,
    ST_HS_DEAD,
    ST_HS_ON,
    ST_LS_WAIT,
    ST_LS_DEAD,
    ST_LS_ON,
    ST_MID_WAIT,
    ST_MID_DEAD,
    ST_DE_BLANK,
    ST_DE_WATCH,
    ST_DE_DONE
  } seq_st_e;

  localparam int TMR_DEAD  = 0;
  localparam int TMR_TOUT  = 1;
  localparam int TMR_BLANK = 2;
  localparam int TMR_COUNT = 3;

  // Three-level code to command; the unused code falls to mid
  function automatic cmd_e decode_pwm(input logic [1:0] code);
    case (code)
      2'b00:   return CMD_LO;
      2'b01:   return CMD_HI;
      default: return CMD_MID;
    endcase
  endfunction

  // Turn-off step that opens the sequence of each command
  function automatic seq_st_e entry_state(input cmd_e c);
    case (c)
      CMD_LO:  return ST_LS_WAIT;
      CMD_HI:  return ST_HS_WAIT;
      default: return ST_MID_WAIT;
    endcase
  endfunction

  function automatic logic is_dead(input seq_st_e s);
    return (s == ST_HS_DEAD) || (s == ST_LS_DEAD) || (s == ST_MID_DEAD);
  endfunction

  function automatic logic ls_on_state(input seq_st_e s);
    return (s == ST_LS_ON) || (s == ST_DE_BLANK) || (s == ST_DE_WATCH);
  endfunction

endpackage

// File: rtl/tpg_timer.sv
module tpg_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] START = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= START;
    else if (run && (cnt_q != '0))    cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

  AST_TMR_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == START)); // R4

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired); // R6

endmodule

// File: rtl/tpg_seq_fsm.sv
module tpg_seq_fsm
  import tpg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic                 en_ok,
  input  logic                 sw_low,
  input  logic                 hs_off_sense,
  input  logic                 ls_off_sense,
  input  logic                 zc_det,
  input  logic [TMR_COUNT-1:0] tmr_done,
  output logic [TMR_COUNT-1:0] tmr_load,
  output logic [TMR_COUNT-1:0] tmr_run,
  output logic                 hs_gate,
  output logic                 ls_gate
);
  seq_st_e state_q, state_n;
  cmd_e    cmd_q;
  logic    hs_q, ls_q;

  // Named events for the assertions
  logic cmd_change;
  logic tout_fire;
  logic ls_path_ready;
  logic zc_release;

  assign cmd_change    = (cmd != cmd_q);
  assign ls_path_ready = sw_low && hs_off_sense;
  assign tout_fire     = (state_q == ST_LS_WAIT) && tmr_done[TMR_TOUT];
  assign zc_release    = (state_q == ST_DE_WATCH) && zc_det;

  always_comb begin
    state_n = state_q;
    if (!en_ok) begin
      state_n = ST_IDLE;
    end else if ((state_q == ST_IDLE) || cmd_change) begin
      state_n = entry_state(cmd);
    end else begin
      case (state_q)
        ST_HS_WAIT:  if (ls_off_sense)          state_n = ST_HS_DEAD;
        ST_HS_DEAD:  if (tmr_done[TMR_DEAD])    state_n = ST_HS_ON;
        ST_LS_WAIT: begin
          if (tout_fire)                        state_n = ST_LS_ON;
          else if (ls_path_ready)               state_n = ST_LS_DEAD;
        end
        ST_LS_DEAD:  if (tmr_done[TMR_DEAD])    state_n = ST_LS_ON;
        ST_MID_WAIT: if (hs_off_sense)          state_n = ST_MID_DEAD;
        ST_MID_DEAD: if (tmr_done[TMR_DEAD])    state_n = ST_DE_BLANK;
        ST_DE_BLANK: if (tmr_done[TMR_BLANK])   state_n = ST_DE_WATCH;
        ST_DE_WATCH: if (zc_release)            state_n = ST_DE_DONE;
        default:                                state_n = state_q;
      endcase
    end
  end

  // Timers are armed on the edge that enters their state
  always_comb begin
    tmr_load[TMR_DEAD]  = is_dead(state_n) && (state_n != state_q);
    tmr_load[TMR_TOUT]  = (state_n == ST_LS_WAIT) && (state_q != ST_LS_WAIT);
    tmr_load[TMR_BLANK] = (state_n == ST_DE_BLANK) && (state_q != ST_DE_BLANK);
    tmr_run[TMR_DEAD]   = is_dead(state_q);
    tmr_run[TMR_TOUT]   = (state_q == ST_LS_WAIT);
    tmr_run[TMR_BLANK]  = (state_q == ST_DE_BLANK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_LO;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cmd_q   <= cmd;
      hs_q    <= (state_n == ST_HS_ON);
      ls_q    <= ls_on_state(state_n);
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate)); // R9

  AST_HS_AFTER_LS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ($past(!ls_gate) && $past(tmr_done[TMR_DEAD]))); // R2

  AST_TIMEOUT_FORCES_LS: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_fire && en_ok && !cmd_change) |=> ls_gate); // R4

  AST_BLANK_HOLDS_LS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DE_BLANK) && en_ok && !cmd_change) |=> ls_gate); // R6

  AST_ZC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_release && en_ok && !cmd_change) |=> (!ls_gate && !hs_gate)); // R7

  AST_CMD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_change && en_ok) |=> (!hs_gate && !ls_gate)); // R10

endmodule

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq
  import tpg_pkg::*;
#(
  parameter int unsigned DEAD_CYC  = 8,
  parameter int unsigned TOUT_CYC  = 200,
  parameter int unsigned BLANK_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_state,
  input  logic       en_ok,
  input  logic       sw_low,
  input  logic       hs_off_sense,
  input  logic       ls_off_sense,
  input  logic       zc_det,
  output logic       hs_gate,
  output logic       ls_gate
);
  function automatic int unsigned tmr_len(input int idx);
    case (idx)
      TMR_DEAD: return DEAD_CYC;
      TMR_TOUT: return TOUT_CYC;
      default:  return BLANK_CYC;
    endcase
  endfunction

  cmd_e                 cmd;
  logic [TMR_COUNT-1:0] tmr_load;
  logic [TMR_COUNT-1:0] tmr_run;
  logic [TMR_COUNT-1:0] tmr_done;

  assign cmd = decode_pwm(pwm_state);

  for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
    tpg_timer #(.LEN(tmr_len(g))) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load[g]),
      .run     (tmr_run[g]),
      .expired (tmr_done[g])
    );
  end

  tpg_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .en_ok        (en_ok),
    .sw_low       (sw_low),
    .hs_off_sense (hs_off_sense),
    .ls_off_sense (ls_off_sense),
    .zc_det       (zc_det),
    .tmr_done     (tmr_done),
    .tmr_load     (tmr_load),
    .tmr_run      (tmr_run),
    .hs_gate      (hs_gate),
    .ls_gate      (ls_gate)
  );

  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> (!hs_gate && !ls_gate)); // R8

endmodule

// File: tb/tri_pwm_gate_seq_bench.sv
module tri_pwm_gate_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm_state = 2'b00;
  logic       en_ok = 1'b0;
  logic       sw_low = 1'b0;
  logic       hs_off_sense = 1'b0;
  logic       ls_off_sense = 1'b0;
  logic       zc_det = 1'b0;
  logic       hs_gate, ls_gate;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  tri_pwm_gate_seq #(.DEAD_CYC(2), .TOUT_CYC(6), .BLANK_CYC(3)) u_tri_pwm_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_state(pwm_state), .en_ok(en_ok),
    .sw_low(sw_low), .hs_off_sense(hs_off_sense), .ls_off_sense(ls_off_sense),
    .zc_det(zc_det), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  // {en, pwm[1:0], sw_low, hs_off, ls_off, zc, exp_hs, exp_ls}; dead=2, timeout=6, blank=3
  localparam logic [8:0] VEC [58] = '{
    9'b1_00_1110_00, 9'b1_00_1110_00, 9'b1_00_1110_00, 9'b1_00_1110_01, // R3 rows 0-3
    9'b1_00_1110_01,                                                    // R3
    9'b1_01_1110_00, 9'b1_01_1110_00, 9'b1_01_1110_00, 9'b1_01_1110_10, // R2 rows 5-8
    9'b1_01_1110_10,                                                    // R2
    9'b1_00_0110_00, 9'b1_00_0110_00, 9'b1_00_0110_00, 9'b1_00_0110_00, // R4 rows 10-13
    9'b1_00_0110_00, 9'b1_00_0110_00, 9'b1_00_0110_01, 9'b1_00_0110_01, // R4 forced on at 16
    9'b1_10_1110_00, 9'b1_10_1110_00, 9'b1_10_1110_00, 9'b1_10_1110_01, // R5 rows 18-21
    9'b1_10_1111_01, 9'b1_10_1111_01, 9'b1_10_1111_01, 9'b1_10_1110_01, // R6 zc ignored
    9'b1_10_1111_00, 9'b1_10_1110_00,                                   // R7 release
    9'b1_01_1110_00, 9'b1_01_1100_00, 9'b1_01_1110_00,                  // R2 waits sense
    9'b1_00_1110_00, 9'b1_00_1110_00, 9'b1_00_1110_00, 9'b1_00_1110_01, // R10 abort in dead
    9'b0_00_1110_00, 9'b0_01_1110_00, 9'b1_01_1110_00, 9'b1_01_1110_00, // R8 rows 35-38
    9'b1_01_1110_00, 9'b1_01_1110_10, 9'b0_01_1110_00,                  // R8
    9'b1_00_1010_00, 9'b1_00_1010_00, 9'b1_00_1110_00, 9'b1_00_1110_00, // R3 waits hs sense
    9'b1_00_1110_01,                                                    // R3
    9'b1_01_1110_00, 9'b1_01_1110_00, 9'b1_01_1110_00, 9'b1_01_1110_10, // R2 rows 47-50
    9'b1_00_0110_00, 9'b1_00_0110_00, 9'b1_00_0110_00, 9'b1_00_0110_00, // R4 rows 51-54
    9'b1_00_0110_00, 9'b1_00_0110_00, 9'b1_00_1110_01                   // R4 expiry beats sw_low
  };

  function automatic string row_req(input int i);
    if (i < 5)  return "R3";
    if (i < 10) return "R2";
    if (i < 18) return "R4";
    if (i < 22) return "R5";
    if (i < 26) return "R6";
    if (i < 28) return "R7";
    if (i < 31) return "R2";
    if (i < 35) return "R10";
    if (i < 42) return "R8";
    if (i < 47) return "R3";
    if (i < 51) return "R2";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic exp_h, input logic exp_l);
    checks++;
    if (hs_gate !== exp_h || ls_gate !== exp_l) begin
      errs++;
      $display("FAIL %s: hs/ls actual=%b%b expected=%b%b", req, hs_gate, ls_gate, exp_h, exp_l);
    end
  endtask

  task automatic chk_overlap();
    checks++;
    if (hs_gate && ls_gate) begin
      errs++;
      $display("FAIL R9: hs/ls actual=11 expected=not both high");
    end
  endtask

  task automatic apply(input logic [6:0] in);
    @(negedge clk);
    {en_ok, pwm_state, sw_low, hs_off_sense, ls_off_sense, zc_det} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 20000);
    errs++;
    checks++;
    $display("FAIL R1: watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(7'b0_00_0000);
    chk("R1", 1'b0, 1'b0);

    for (int i = 0; i < 58; i++) begin
      apply(VEC[i][8:2]);
      chk(row_req(i), VEC[i][1], VEC[i][0]);
      chk_overlap();
    end

    // R11: code 11 acts as mid; switching 11 -> 10 is not a command change
    apply(7'b1_11_1110); chk("R11", 1'b0, 1'b0);
    apply(7'b1_11_1110); chk("R11", 1'b0, 1'b0);
    apply(7'b1_11_1110); chk("R11", 1'b0, 1'b0);
    apply(7'b1_11_1110); chk("R11", 1'b0, 1'b1);
    apply(7'b1_10_1110); chk("R11", 1'b0, 1'b1);

    // R1: asynchronous reset drops a high-side gate at once
    apply(7'b1_01_1110); chk("R2", 1'b0, 1'b0);
    apply(7'b1_01_1110);
    apply(7'b1_01_1110);
    apply(7'b1_01_1110); chk("R2", 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R1", 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule